// File: doc/BRIEF.md
# DDR Read Burst Truncation Sequencer

This block produces the command stream for a single DDR SDRAM read burst together with the command that comes after it. A requester gives a bank, the number of data pairs it wants (each clock of data carries one pair, because of the 2n prefetch), an auto-precharge flag and a follow-on action. The block then issues READ and, when needed, a burst stop (BST), a PRECHARGE or a WRITE. Each command lands on the exact cycle that cuts the burst to the requested length. The same timing keeps the data bus clear before a write and keeps the bank closed for the row precharge time.

Commands leave on a three-bit bus, one per clock, and NOP fills every cycle that has no scheduled command. A data-valid output marks the cycles in which read data occupies the bus. A half-cycle flag goes with it when the CAS latency has a half-clock part. A ready/valid handshake holds off the next request until the sequence and any precharge wait are over. A request the rules forbid gets a one-cycle error pulse and produces no commands.

Top module: `ddr_rdtrunc_seq`

## Requirements
- R1: A request accepted with `req_valid` and `req_ready` both high, and valid under R8, puts READ (code 1) on `cmd` in the next cycle, with `cmd_bank` equal to the request bank and `cmd_ap` equal to the auto-precharge flag. `req_ready` is low from that READ cycle until the sequence ends.
- R2: `data_valid` is high for exactly `pairs` consecutive cycles, starting CLE cycles after READ, where CLE = CL_INT + CL_HALF (the CAS latency rounded up to whole cycles).
- R3: When follow is none (0) or write (1) and `pairs` is below BL/2, BST (code 2) comes exactly `pairs` cycles after READ. A full-length read gets no BST.
- R4: When follow is write (1), WRITE (code 4) comes `pairs` + CLE cycles after READ, on the request bank, and never while `data_valid` is high.
- R5: When follow is precharge (2), PRE (code 3) comes on the request bank exactly `pairs` cycles after READ. PRE is never issued after a READ that had auto precharge set.
- R6: After PRE, the next READ comes no earlier than TRP cycles later. `req_ready` rises at cycle L+1 after READ, where L is max(CLE+pairs-1, pairs+TRP-2) for precharge, CLE+pairs for write, and CLE+pairs-1 for none.
- R7: A full-length read with auto precharge set gives the same data window and the same `req_ready` timing as the same read followed by PRE at BL/2 cycles, and issues no PRE.
- R8: A request with `pairs` of 0 or above BL/2, with follow code 3, or with auto precharge set together with a follow action or a short burst is rejected. `req_err` pulses in the next cycle, `cmd` stays NOP and `req_ready` stays high.
- R9: Every cycle without a scheduled command shows NOP (code 0) on `cmd`. The follow codes are none 0, write 1, precharge 2; code 3 is reserved.
- R10: When CL_HALF is 1, `data_half` is high in exactly the cycles where `data_valid` is high. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_pairs | input | PAIR_W | Number of data pairs wanted |
| req_ap | input | 1 | Auto precharge on the READ |
| req_follow | input | 2 | Follow-on action: 0 none, 1 write, 2 precharge |
| cmd | output | 3 | Command: 0 NOP, 1 READ, 2 BST, 3 PRE, 4 WRITE |
| cmd_bank | output | BANK_W | Bank of the command on `cmd` |
| cmd_ap | output | 1 | Auto-precharge bit sent with READ |
| data_valid | output | 1 | Read data occupies the bus |
| data_half | output | 1 | Data window is shifted by half a clock |
| req_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The stimulus sweeps every pair count from 1 to a full burst against each follow action. This separates BST placement from PRE placement, and separates a cut burst from a completed one. Full-length reads with auto precharge run next to full-length reads followed by PRE, which shows the two give the same data window and the same ready timing. Pair counts of 0 and above the burst, the reserved follow code, and auto precharge combined with cutting all check that rejection issues nothing. Requests are driven back to back in the first ready cycle, which exposes any early or late rise of ready, including the precharge wait.

// File: rtl/ddr_rdtrunc_pkg.sv
package ddr_rdtrunc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_BST   = 3'd2,
    CMD_PRE   = 3'd3,
    CMD_WRITE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    FOL_NONE  = 2'd0,
    FOL_WRITE = 2'd1,
    FOL_PRE   = 2'd2,
    FOL_RSVD  = 2'd3
  } follow_e;

endpackage

// File: rtl/ddr_rdtrunc_check.sv
// Validates a request and works out the last busy cycle of its sequence,
// counted from the READ cycle.
module ddr_rdtrunc_check
  import ddr_rdtrunc_pkg::*;
#(
  parameter int PAIRS  = 4,
  parameter int PAIR_W = 3,
  parameter int CL_EFF = 2,
  parameter int TRP    = 3,
  parameter int K_W    = 4
) (
  input  logic [PAIR_W-1:0] pairs,
  input  logic              ap,
  input  logic [1:0]        follow,
  output logic              ok,
  output logic [K_W-1:0]    last
);

  int p_i;
  int data_end;
  int trp_end;
  int last_i;

  always_comb begin
    p_i      = int'(pairs);
    data_end = CL_EFF + p_i - 1;
    trp_end  = p_i + TRP - 2;

    ok = (p_i != 0) && (p_i <= PAIRS) && (follow != FOL_RSVD);
    // auto precharge admits neither a follow action nor a cut burst
    if (ap && ((follow != FOL_NONE) || (p_i != PAIRS))) begin
      ok = 1'b0;
    end

    if (ap || (follow == FOL_PRE)) begin
      last_i = (data_end > trp_end) ? data_end : trp_end;
    end else if (follow == FOL_WRITE) begin
      last_i = CL_EFF + p_i;
    end else begin
      last_i = data_end;
    end
    last = K_W'(last_i);
  end

endmodule

// File: rtl/ddr_rdtrunc_ctl.sv
// Request handshake, sequence counter and held request fields.
// Exposes next-state values so the command stage can register its outputs.
module ddr_rdtrunc_ctl #(
  parameter int BANK_W = 2,
  parameter int PAIR_W = 3,
  parameter int K_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PAIR_W-1:0] req_pairs,
  input  logic              req_ap,
  input  logic [1:0]        req_follow,
  input  logic              chk_ok,
  input  logic [K_W-1:0]    chk_last,
  output logic              req_ready,
  output logic              req_err,
  output logic              act_nx,
  output logic [K_W-1:0]    k_nx,
  output logic [BANK_W-1:0] bank_nx,
  output logic [PAIR_W-1:0] pairs_nx,
  output logic              ap_nx,
  output logic [1:0]        follow_nx
);

  logic              busy_q, busy_d;
  logic [K_W-1:0]    k_q, k_d;
  logic [K_W-1:0]    last_q;
  logic [BANK_W-1:0] bank_q;
  logic [PAIR_W-1:0] pairs_q;
  logic              ap_q;
  logic [1:0]        follow_q;
  logic              err_q;

  logic accept, start, reject, k_en;

  always_comb begin
    accept = req_valid & ~busy_q;
    start  = accept & chk_ok;
    reject = accept & ~chk_ok;
    k_en   = start | busy_q;

    busy_d = busy_q;
    k_d    = k_q;
    if (start) begin
      busy_d = 1'b1;
      k_d    = '0;
    end else if (busy_q) begin
      if (k_q == last_q) begin
        busy_d = 1'b0;
      end else begin
        k_d = k_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0;
    end else if (k_en) begin
      k_q <= k_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      bank_q   <= '0;
      pairs_q  <= '0;
      ap_q     <= 1'b0;
      follow_q <= '0;
    end else if (start) begin
      last_q   <= chk_last;
      bank_q   <= req_bank;
      pairs_q  <= req_pairs;
      ap_q     <= req_ap;
      follow_q <= req_follow;
    end
  end

  assign req_ready = ~busy_q;
  assign req_err   = err_q;
  assign act_nx    = busy_d;
  assign k_nx      = k_d;
  assign bank_nx   = start ? req_bank   : bank_q;
  assign pairs_nx  = start ? req_pairs  : pairs_q;
  assign ap_nx     = start ? req_ap     : ap_q;
  assign follow_nx = start ? req_follow : follow_q;

endmodule

// File: rtl/ddr_rdtrunc_cmd.sv
// Decodes the next sequence step into a registered command and data window.
module ddr_rdtrunc_cmd
  import ddr_rdtrunc_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int PAIR_W  = 3,
  parameter int K_W     = 4,
  parameter int PAIRS   = 4,
  parameter int CL_EFF  = 2,
  parameter int CL_HALF = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_nx,
  input  logic [K_W-1:0]    k_nx,
  input  logic [BANK_W-1:0] bank_nx,
  input  logic [PAIR_W-1:0] pairs_nx,
  input  logic              ap_nx,
  input  logic [1:0]        follow_nx,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ap,
  output logic              data_valid,
  output logic              data_half
);

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic              ap_d, ap_q;
  logic              dv_d, dv_q;
  int                k_i;
  int                p_i;

  always_comb begin
    k_i    = int'(k_nx);
    p_i    = int'(pairs_nx);
    cmd_d  = CMD_NOP;
    dv_d   = 1'b0;
    if (act_nx) begin
      if (k_i == 0) begin
        cmd_d = CMD_READ;
      end else if ((follow_nx == FOL_PRE) && (k_i == p_i)) begin
        cmd_d = CMD_PRE;
      end else if ((follow_nx != FOL_PRE) && (p_i < PAIRS) && (k_i == p_i)) begin
        cmd_d = CMD_BST;
      end else if ((follow_nx == FOL_WRITE) && (k_i == p_i + CL_EFF)) begin
        cmd_d = CMD_WRITE;
      end
      dv_d = (k_i >= CL_EFF) && (k_i < CL_EFF + p_i);
    end
    bank_d = (cmd_d == CMD_NOP) ? '0 : bank_nx;
    ap_d   = (cmd_d == CMD_READ) & ap_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      ap_q   <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      ap_q   <= ap_d;
      dv_q   <= dv_d;
    end
  end

  assign cmd        = cmd_q;
  assign cmd_bank   = bank_q;
  assign cmd_ap     = ap_q;
  assign data_valid = dv_q;

  generate
    if (CL_HALF != 0) begin : g_half
      assign data_half = dv_q;
    end else begin : g_whole
      assign data_half = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ddr_rdtrunc_seq.sv
module ddr_rdtrunc_seq #(
  parameter int BANK_W  = 2,
  parameter int BL      = 8,
  parameter int CL_INT  = 2,
  parameter int CL_HALF = 0,
  parameter int TRP     = 3,
  localparam int PAIRS  = BL / 2,
  localparam int PAIR_W = $clog2(PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PAIR_W-1:0] req_pairs,
  input  logic              req_ap,
  input  logic [1:0]        req_follow,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ap,
  output logic              data_valid,
  output logic              data_half,
  output logic              req_err
);

  localparam int CL_EFF = CL_INT + CL_HALF;
  localparam int K_MAX  = PAIRS + CL_EFF + TRP + 1;
  localparam int K_W    = $clog2(K_MAX + 1);

  logic              chk_ok;
  logic [K_W-1:0]    chk_last;
  logic              act_nx;
  logic [K_W-1:0]    k_nx;
  logic [BANK_W-1:0] bank_nx;
  logic [PAIR_W-1:0] pairs_nx;
  logic              ap_nx;
  logic [1:0]        follow_nx;

  ddr_rdtrunc_check #(
    .PAIRS(PAIRS), .PAIR_W(PAIR_W), .CL_EFF(CL_EFF), .TRP(TRP), .K_W(K_W)
  ) u_chk (
    .pairs  (req_pairs),
    .ap     (req_ap),
    .follow (req_follow),
    .ok     (chk_ok),
    .last   (chk_last)
  );

  ddr_rdtrunc_ctl #(
    .BANK_W(BANK_W), .PAIR_W(PAIR_W), .K_W(K_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_pairs  (req_pairs),
    .req_ap     (req_ap),
    .req_follow (req_follow),
    .chk_ok     (chk_ok),
    .chk_last   (chk_last),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .act_nx     (act_nx),
    .k_nx       (k_nx),
    .bank_nx    (bank_nx),
    .pairs_nx   (pairs_nx),
    .ap_nx      (ap_nx),
    .follow_nx  (follow_nx)
  );

  ddr_rdtrunc_cmd #(
    .BANK_W(BANK_W), .PAIR_W(PAIR_W), .K_W(K_W),
    .PAIRS(PAIRS), .CL_EFF(CL_EFF), .CL_HALF(CL_HALF)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_nx     (act_nx),
    .k_nx       (k_nx),
    .bank_nx    (bank_nx),
    .pairs_nx   (pairs_nx),
    .ap_nx      (ap_nx),
    .follow_nx  (follow_nx),
    .cmd        (cmd),
    .cmd_bank   (cmd_bank),
    .cmd_ap     (cmd_ap),
    .data_valid (data_valid),
    .data_half  (data_half)
  );

endmodule

// File: rtl/ddr_rdtrunc_sva.sv
module ddr_rdtrunc_sva #(
  parameter int TRP = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       chk_ok,
  input logic [2:0] cmd,
  input logic       cmd_ap,
  input logic       data_valid,
  input logic       data_half,
  input logic       req_err
);

  logic [7:0] gap_q;
  logic       ap_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= 8'hFF;
      ap_seen_q <= 1'b0;
    end else begin
      if (cmd == 3'd3) begin
        gap_q <= 8'd0;
      end else if (gap_q != 8'hFF) begin
        gap_q <= gap_q + 8'd1;
      end
      if (cmd == 3'd1) begin
        ap_seen_q <= cmd_ap;
      end
    end
  end

  p_read_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && chk_ok) |=> (cmd == 3'd1));

  p_busy_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> !req_ready);

  p_write_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |-> !data_valid);

  p_pre_without_ap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3) |-> !ap_seen_q);

  p_trp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd1) && (gap_q != 8'hFF)) |-> (gap_q >= 8'(TRP - 1)));

  p_reject_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ((cmd == 3'd0) && req_ready));

  p_cmd_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd <= 3'd4);

  p_half_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_half |-> data_valid);

endmodule

bind ddr_rdtrunc_seq ddr_rdtrunc_sva #(.TRP(TRP)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .chk_ok     (chk_ok),
  .cmd        (cmd),
  .cmd_ap     (cmd_ap),
  .data_valid (data_valid),
  .data_half  (data_half),
  .req_err    (req_err)
);

// File: tb/ddr_rdtrunc_seq_bench.sv
module ddr_rdtrunc_seq_bench;

  localparam int BANK_W  = 2;
  localparam int BL      = 8;
  localparam int CL_INT  = 2;
  localparam int CL_HALF = 1;
  localparam int TRP     = 3;
  localparam int PAIRS   = BL / 2;
  localparam int PAIR_W  = $clog2(PAIRS + 1);
  localparam int CLE     = CL_INT + CL_HALF;
  localparam int WATCHDOG = 150000;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank;
  logic [PAIR_W-1:0] req_pairs;
  logic              req_ap;
  logic [1:0]        req_follow;
  logic [2:0]        cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic              cmd_ap;
  logic              data_valid;
  logic              data_half;
  logic              req_err;

  int n_checks;
  int n_fail;
  bit finished;

  ddr_rdtrunc_seq #(
    .BANK_W(BANK_W), .BL(BL), .CL_INT(CL_INT), .CL_HALF(CL_HALF), .TRP(TRP)
  ) u_ddr_rdtrunc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_pairs(req_pairs), .req_ap(req_ap),
    .req_follow(req_follow), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .data_valid(data_valid), .data_half(data_half), .req_err(req_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic bit exp_ok(int p, bit ap, int f);
    if (p < 1 || p > PAIRS || f == 3) return 1'b0;
    if (ap && (f != 0 || p != PAIRS)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_last(int p, bit ap, int f);
    int a, b;
    a = CLE + p - 1;
    b = p + TRP - 2;
    if (ap || f == 2) return (a > b) ? a : b;
    if (f == 1) return CLE + p;
    return a;
  endfunction

  function automatic int exp_cmd(int k, int p, int f);
    if (k == 0) return 1;
    if (f == 2 && k == p) return 3;
    if (f != 2 && p < PAIRS && k == p) return 2;
    if (f == 1 && k == p + CLE) return 4;
    return 0;
  endfunction

  // called at a negedge with req_ready expected high; returns at a negedge
  task automatic run_req(int bank, int p, bit ap, int f);
    int last;
    int c;
    check("R6 ready before request", int'(req_ready), 1);
    req_valid  = 1'b1;
    req_bank   = BANK_W'(bank);
    req_pairs  = PAIR_W'(p);
    req_ap     = ap;
    req_follow = 2'(f);
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_ok(p, ap, f)) begin
      check("R8 err pulse", int'(req_err), 1);
      check("R8 no command", int'(cmd), 0);
      check("R8 ready kept", int'(req_ready), 1);
      @(negedge clk);
      check("R8 err single", int'(req_err), 0);
      check("R8 still no command", int'(cmd), 0);
      return;
    end
    last = exp_last(p, ap, f);
    for (int k = 0; k <= last + 1; k++) begin
      c = (k <= last) ? exp_cmd(k, p, f) : 0;
      if (c == 1) begin
        check("R1 READ", int'(cmd), 1);
        check("R1 READ bank", int'(cmd_bank), bank);
        check("R1 READ ap", int'(cmd_ap), int'(ap));
      end else if (c == 2) begin
        check("R3 BST", int'(cmd), 2);
      end else if (c == 3) begin
        check("R5 PRE", int'(cmd), 3);
        check("R5 PRE bank", int'(cmd_bank), bank);
      end else if (c == 4) begin
        check("R4 WRITE", int'(cmd), 4);
        check("R4 WRITE bank", int'(cmd_bank), bank);
        check("R4 no data under WRITE", int'(data_valid), 0);
      end else begin
        check("R9 NOP", int'(cmd), 0);
      end
      check("R2 data window", int'(data_valid),
            int'(k >= CLE && k < CLE + p));
      check("R10 half flag", int'(data_half), int'(data_valid));
      if (ap) check("R7 ready timing", int'(req_ready), int'(k == last + 1));
      else    check("R6 ready timing", int'(req_ready), int'(k == last + 1));
      if (k <= last) @(negedge clk);
    end
  endtask

  initial begin
    #(20 * WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    report();
  end

  initial begin
    int seed;
    n_checks = 0;
    n_fail = 0;
    finished = 1'b0;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_bank = '0;
    req_pairs = '0;
    req_ap = 1'b0;
    req_follow = '0;
    repeat (3) @(negedge clk);
    check("R9 reset cmd", int'(cmd), 0);
    check("R2 reset data_valid", int'(data_valid), 0);
    check("R8 reset err", int'(req_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);

    // directed corners
    run_req(1, PAIRS, 1'b0, 2);   // R5 full burst then PRE
    run_req(1, PAIRS, 1'b1, 0);   // R7 auto precharge equivalent
    run_req(2, 1, 1'b0, 1);       // R4 shortest cut then WRITE
    run_req(3, 1, 1'b0, 0);       // R3 BST after one pair
    run_req(0, PAIRS, 1'b0, 0);   // R3 full burst, no BST
    run_req(0, PAIRS, 1'b0, 1);   // R4 full burst then WRITE
    run_req(2, 2, 1'b0, 2);       // R5 PRE cut
    run_req(1, 0, 1'b0, 0);       // R8 zero pairs
    run_req(1, PAIRS + 1, 1'b0, 0); // R8 too many pairs
    run_req(1, 2, 1'b0, 3);       // R8 reserved follow
    run_req(1, PAIRS, 1'b1, 2);   // R8 PRE with auto precharge
    run_req(1, 2, 1'b1, 0);       // R8 cut with auto precharge

    for (int i = 0; i < 80; i++) begin
      run_req(int'($urandom % 4), int'($urandom % (PAIRS + 2)),
              (($urandom % 4) == 0), int'($urandom % 4));
    end
    report();
  end

endmodule